// File: doc/BRIEF.md
# Microprogram Sequencer with Two-Level Dispatch

This block is the control unit of a microcoded processor. A writable control store holds the microinstructions. Each microinstruction carries a field of raw control-line bits, a two-bit sequencing code and a dispatch-table select. Exactly one microinstruction is current in each cycle. Its control field drives the control lines directly, with no decoding, for the whole of that cycle.

The sequencing code chooses the next micro-address. It can step to the following entry, restart at entry 0 (the fetch routine), or jump through a dispatch table. The dispatch store is two-dimensional. The table select in the microinstruction picks the row. The instruction opcode presented on the input picks the column. The stored entry gives the target micro-address, together with a mapped flag. An entry whose flag is clear sends control to a fixed error micro-address.

Both the control store and the dispatch tables are loaded through simple write ports. Loading is allowed while reset is held and while the sequencer runs. The control outputs and the current micro-address both come from registers that update on the same edge.

Top module: `useq_top`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, uaddr_o is 0 and ctrl_o is 0. In the next cycle uaddr_o is still 0, and ctrl_o shows the control field of store entry 0.
- R2: Microinstruction layout (default parameters): bits [18:3] are the control field, bits [2:1] are the sequencing code and bit [0] is the dispatch-table select. Once the start cycle has passed, ctrl_o always equals the control field of the store entry at uaddr_o.
- R3: Sequencing code 00 moves uaddr_o to uaddr_o+1 in the next cycle. The address wraps from 63 to 0.
- R4: Sequencing code 01 moves uaddr_o to 0 in the next cycle.
- R5: The reserved sequencing code 11 behaves like 01 and moves uaddr_o to 0.
- R6: Sequencing code 10 moves uaddr_o to the target of the dispatch entry at (row = table select, column = opcode_i) when that entry's mapped flag is set. Entry layout: bit [6] is the mapped flag and bits [5:0] are the target.
- R7: A dispatch to an entry whose mapped flag is clear moves uaddr_o to ERR_UADDR (default 63).
- R8: The table select decides the row. The same opcode reaches different targets through table 0 and through table 1.
- R9: opcode_i is used only in a cycle whose current microinstruction has code 10. Changing it in any other cycle does not change the address sequence.
- R10: A control-store write made while the sequencer runs is seen the next time that entry becomes current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Instruction opcode, used as the dispatch column |
| cs_we_i | input | 1 | Control-store write enable |
| cs_waddr_i | input | 6 | Control-store write address |
| cs_wdata_i | input | 19 | Microinstruction to write |
| dt_we_i | input | 1 | Dispatch-table write enable |
| dt_sel_i | input | 1 | Dispatch table (row) to write |
| dt_col_i | input | 6 | Dispatch column (opcode) to write |
| dt_wdata_i | input | 7 | Dispatch entry: mapped flag and target |
| ctrl_o | output | 16 | Control lines of the current microinstruction |
| uaddr_o | output | 6 | Current micro-address |

## Verification
The assertions check, in every cycle, the address transition that each sequencing code requires: the increment with wrap, the restart for codes 01 and 11, the jump to a mapped target, the fall-back to the error address, and the zeroed outputs during the start cycle. Some behaviours can only be shown by the bench's scenarios, because they depend on what was loaded. These are: ctrl_o matching the loaded control field, the two tables giving different targets for one opcode, opcode changes outside dispatch cycles having no effect, and a store write made at run time showing up later.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    SEQ_NEXT  = 2'b00,
    SEQ_FETCH = 2'b01,
    SEQ_DISP  = 2'b10,
    SEQ_RSVD  = 2'b11
  } seq_e;

  localparam int unsigned SEQ_W = 2;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int unsigned UW      = 19,
  parameter int unsigned UADDR_W = 6
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [UADDR_W-1:0] waddr_i,
  input  logic [UW-1:0]      wdata_i,
  input  logic [UADDR_W-1:0] raddr_i,
  output logic [UW-1:0]      rdata_o
);
  localparam int unsigned DEPTH = 1 << UADDR_W;

  logic [UW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
  parameter int unsigned N_TABLES  = 2,
  parameter int unsigned TSEL_W    = 1,
  parameter int unsigned OPC_W     = 6,
  parameter int unsigned UADDR_W   = 6,
  parameter int unsigned ERR_UADDR = 63
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [TSEL_W-1:0]  wsel_i,
  input  logic [OPC_W-1:0]   wcol_i,
  input  logic [UADDR_W:0]   wdata_i,
  input  logic [TSEL_W-1:0]  tsel_i,
  input  logic [OPC_W-1:0]   opc_i,
  output logic               hit_o,
  output logic [UADDR_W-1:0] target_o
);
  localparam int unsigned COLS = 1 << OPC_W;
  localparam int unsigned EW   = UADDR_W + 1;

  logic [EW-1:0] row_rd [N_TABLES];
  logic [EW-1:0] ent;

  for (genvar t = 0; t < N_TABLES; t++) begin : g_tbl
    logic [EW-1:0] tbl_q [COLS];
    logic          row_we;

    assign row_we = we_i && (wsel_i == TSEL_W'(t));

    always_ff @(posedge clk_i) begin
      if (row_we) tbl_q[wcol_i] <= wdata_i;
    end

    assign row_rd[t] = tbl_q[opc_i];
  end

  // an out-of-range row select reads as unmapped
  always_comb begin
    ent = '0;
    for (int t = 0; t < N_TABLES; t++) begin
      if (tsel_i == TSEL_W'(t)) ent = row_rd[t];
    end
  end

  assign hit_o    = ent[UADDR_W];
  assign target_o = hit_o ? ent[UADDR_W-1:0] : UADDR_W'(ERR_UADDR);
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int unsigned UADDR_W = 6
) (
  input  logic               start_i,
  input  seq_e               seq_i,
  input  logic [UADDR_W-1:0] uaddr_i,
  input  logic [UADDR_W-1:0] disp_i,
  output logic [UADDR_W-1:0] nxt_o
);
  always_comb begin
    if (start_i) begin
      nxt_o = '0;
    end else begin
      unique case (seq_i)
        SEQ_NEXT: nxt_o = uaddr_i + UADDR_W'(1);
        SEQ_DISP: nxt_o = disp_i;
        default:  nxt_o = '0;  // fetch and reserved restart
      endcase
    end
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int unsigned CTRL_W    = 16,
  parameter int unsigned UADDR_W   = 6,
  parameter int unsigned OPC_W     = 6,
  parameter int unsigned N_TABLES  = 2,
  parameter int unsigned ERR_UADDR = 63,
  localparam int unsigned TSEL_W   = (N_TABLES > 1) ? $clog2(N_TABLES) : 1,
  localparam int unsigned UW       = CTRL_W + SEQ_W + TSEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic               cs_we_i,
  input  logic [UADDR_W-1:0] cs_waddr_i,
  input  logic [UW-1:0]      cs_wdata_i,
  input  logic               dt_we_i,
  input  logic [TSEL_W-1:0]  dt_sel_i,
  input  logic [OPC_W-1:0]   dt_col_i,
  input  logic [UADDR_W:0]   dt_wdata_i,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [UADDR_W-1:0] uaddr_o
);
  localparam int unsigned TSEL_LSB = 0;
  localparam int unsigned SEQ_LSB  = TSEL_W;
  localparam int unsigned CTRL_LSB = TSEL_W + SEQ_W;

  logic               start_q;
  logic [UADDR_W-1:0] uaddr_q;
  logic [UW-1:0]      uinst_q;
  logic [UW-1:0]      cs_rd;
  logic [UADDR_W-1:0] nxt;
  logic [UADDR_W-1:0] disp_tgt;
  logic               disp_hit;
  seq_e               seq;
  logic [TSEL_W-1:0]  tsel;

  assign seq  = seq_e'(uinst_q[SEQ_LSB +: SEQ_W]);
  assign tsel = uinst_q[TSEL_LSB +: TSEL_W];

  useq_store #(.UW(UW), .UADDR_W(UADDR_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (cs_we_i),
    .waddr_i (cs_waddr_i),
    .wdata_i (cs_wdata_i),
    .raddr_i (nxt),
    .rdata_o (cs_rd)
  );

  useq_dispatch #(
    .N_TABLES (N_TABLES),
    .TSEL_W   (TSEL_W),
    .OPC_W    (OPC_W),
    .UADDR_W  (UADDR_W),
    .ERR_UADDR(ERR_UADDR)
  ) u_disp (
    .clk_i   (clk_i),
    .we_i    (dt_we_i),
    .wsel_i  (dt_sel_i),
    .wcol_i  (dt_col_i),
    .wdata_i (dt_wdata_i),
    .tsel_i  (tsel),
    .opc_i   (opcode_i),
    .hit_o   (disp_hit),
    .target_o(disp_tgt)
  );

  useq_next #(.UADDR_W(UADDR_W)) u_next (
    .start_i(start_q),
    .seq_i  (seq),
    .uaddr_i(uaddr_q),
    .disp_i (disp_tgt),
    .nxt_o  (nxt)
  );

  // address and microinstruction register load together from the same read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b1;
      uaddr_q <= '0;
      uinst_q <= '0;
    end else begin
      start_q <= 1'b0;
      uaddr_q <= nxt;
      uinst_q <= cs_rd;
    end
  end

  assign ctrl_o  = uinst_q[CTRL_LSB +: CTRL_W];
  assign uaddr_o = uaddr_q;

  // R1
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> (ctrl_o == '0) && (uaddr_o == '0));

  // R3
  seq_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_q && seq == SEQ_NEXT) |=> uaddr_o == UADDR_W'($past(uaddr_o) + 1));

  // R4 R5
  seq_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_q && (seq == SEQ_FETCH || seq == SEQ_RSVD)) |=> uaddr_o == '0);

  // R6
  disp_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_q && seq == SEQ_DISP && disp_hit) |=> uaddr_o == $past(disp_tgt));

  // R7
  disp_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_q && seq == SEQ_DISP && !disp_hit) |=> uaddr_o == UADDR_W'(ERR_UADDR));
endmodule

// File: tb/tb_useq_top.sv
module tb_useq_top;
  localparam int unsigned CW = 16;
  localparam int unsigned AW = 6;
  localparam int unsigned OW = 6;
  localparam int unsigned UW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [OW-1:0] opcode = '0;
  logic          cs_we = 1'b0;
  logic [AW-1:0] cs_waddr = '0;
  logic [UW-1:0] cs_wdata = '0;
  logic          dt_we = 1'b0;
  logic          dt_sel = 1'b0;
  logic [OW-1:0] dt_col = '0;
  logic [AW:0]   dt_wdata = '0;
  logic [CW-1:0] ctrl;
  logic [AW-1:0] uaddr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [UW-1:0] cs_m [64];

  always #2 clk = ~clk;

  useq_top dut (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opcode),
    .cs_we_i(cs_we), .cs_waddr_i(cs_waddr), .cs_wdata_i(cs_wdata),
    .dt_we_i(dt_we), .dt_sel_i(dt_sel), .dt_col_i(dt_col), .dt_wdata_i(dt_wdata),
    .ctrl_o(ctrl), .uaddr_o(uaddr)
  );

  function automatic logic [UW-1:0] mk(logic [CW-1:0] c, logic [1:0] s, logic t);
    return {c, s, t};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(logic [AW-1:0] exp_a, string req);
    @(posedge clk); #1;
    chk({req, " uaddr"}, 32'(uaddr), 32'(exp_a));
    chk({req, " R2 ctrl"}, 32'(ctrl), 32'(cs_m[exp_a][UW-1:3]));
  endtask

  task automatic cs_load(int a, logic [UW-1:0] d);
    cs_m[a] = d;
    cs_we = 1'b1; cs_waddr = AW'(a); cs_wdata = d;
    @(posedge clk); #1;
    cs_we = 1'b0;
  endtask

  task automatic dt_load(logic t, int col, logic [AW:0] d);
    dt_we = 1'b1; dt_sel = t; dt_col = OW'(col); dt_wdata = d;
    @(posedge clk); #1;
    dt_we = 1'b0;
  endtask

  task automatic t_load;
    for (int a = 0; a < 64; a++) cs_m[a] = mk(16'h5500 | 16'(a), 2'b01, 1'b0);
    cs_m[0]  = mk(16'h0A01, 2'b00, 1'b0);
    cs_m[1]  = mk(16'h0B02, 2'b10, 1'b0);
    cs_m[4]  = mk(16'h1004, 2'b10, 1'b1);
    cs_m[6]  = mk(16'h1006, 2'b01, 1'b0);
    cs_m[8]  = mk(16'h2008, 2'b10, 1'b1);
    cs_m[10] = mk(16'h200A, 2'b00, 1'b0);
    cs_m[11] = mk(16'h200B, 2'b11, 1'b0);
    cs_m[12] = mk(16'h300C, 2'b10, 1'b1);
    cs_m[14] = mk(16'h300E, 2'b01, 1'b0);
    cs_m[63] = mk(16'hEEEE, 2'b00, 1'b0);
    for (int a = 0; a < 64; a++) cs_load(a, cs_m[a]);
    for (int t = 0; t < 2; t++)
      for (int c = 0; c < 64; c++) dt_load(t[0], c, '0);
    dt_load(1'b0, 6'h00, {1'b1, 6'd4});
    dt_load(1'b0, 6'h23, {1'b1, 6'd8});
    dt_load(1'b0, 6'h2B, {1'b1, 6'd12});
    dt_load(1'b1, 6'h00, {1'b1, 6'd6});
    dt_load(1'b1, 6'h23, {1'b1, 6'd10});
    dt_load(1'b1, 6'h2B, {1'b1, 6'd14});
  endtask

  task automatic t_reset;
    chk("R1 reset uaddr", 32'(uaddr), 0);
    chk("R1 reset ctrl", 32'(ctrl), 0);
    rst_n = 1'b1;
    #0.5;
    chk("R1 start uaddr", 32'(uaddr), 0);
    chk("R1 start ctrl", 32'(ctrl), 0);
    step(6'd0, "R1 first entry");
  endtask

  task automatic t_rtype;
    opcode = 6'h00;
    step(6'd1, "R3 next");
    step(6'd4, "R6 dispatch t0");
    step(6'd6, "R8 dispatch t1");
    step(6'd0, "R4 fetch");
  endtask

  task automatic t_load_op;
    opcode = 6'h23;
    step(6'd1, "R3 next");
    step(6'd8, "R6 dispatch t0");
    step(6'd10, "R8 dispatch t1");
    opcode = 6'h3F;  // R9 change outside a dispatch cycle
    step(6'd11, "R9 opcode ignored");
    step(6'd0, "R5 reserved code");
  endtask

  task automatic t_store_op;
    opcode = 6'h2B;
    step(6'd1, "R3 next");
    step(6'd12, "R6 dispatch t0");
    step(6'd14, "R8 dispatch t1");
    step(6'd0, "R4 fetch");
  endtask

  task automatic t_unmapped;
    opcode = 6'h05;
    step(6'd1, "R3 next");
    step(6'd63, "R7 unmapped");
    step(6'd0, "R3 wrap");
  endtask

  task automatic t_live_write;
    opcode = 6'h05;
    cs_m[63] = mk(16'h7A7A, 2'b01, 1'b0);
    cs_we = 1'b1; cs_waddr = 6'd63; cs_wdata = cs_m[63];
    step(6'd1, "R10 next");
    cs_we = 1'b0;
    step(6'd63, "R10 new entry");
    step(6'd0, "R10 new fetch code");
  endtask

  initial begin
    t_load;
    t_reset;
    t_rtype;
    t_load_op;
    t_store_op;
    t_unmapped;
    t_live_write;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule